// File: doc/BRIEF.md
# Double-Buffered Panel Configuration Registers with Interrupt Control

This block is the software-visible register file of a display panel controller. Every configuration word written over the register bus lands first in a shadow copy. The timing logic only ever sees a separate working copy. The working copy takes all shadow values in the same clock edge, and only after software has asked for a global load. This keeps a half-written set of timing values away from the timing logic. A requested load waits for the next frame boundary. If the timing logic reports that it is idle, the load happens at once instead.

The same register file holds a combined interrupt register. Four event sources set sticky status bits. A mask field selects which of those bits drive the single interrupt line. A write-one-to-clear field acknowledges events.

The bus is a plain single-cycle register port with byte addresses and a stride of 4. Writes are accepted in the cycle `bus_wr` is high, and reads are combinational from `bus_addr`. The bus has no back-pressure: every access completes in one cycle, so the port carries no valid/ready pair. Event pulses, the frame boundary and the idle level are plain control inputs.

Top module: `cfg_regfile`

## Requirements
- R1: After reset, every shadow and working word, the mask, the status, the load-pending flag and `irq` are all zero.
- R2: A write to configuration word i (byte offset 4*i, i below NUM_CFG) changes only its shadow copy. `cfg_work` holds its value until a global load takes place.
- R3: Writing a word with bit 0 set to offset 0x50 sets the load-pending flag, which reads back at bit 0 of 0x50. A write there with bit 0 clear has no effect.
- R4: While the flag is pending, a cycle with `frame_edge` high raises `load_pulse` in that cycle. At the closing clock edge, every working word takes its shadow value and the flag clears.
- R5: While the flag is pending and `tg_idle` is high, the load happens without waiting for `frame_edge`.
- R6: The first SHADOW_RB configuration words (offsets 0x00, 0x04, 0x08) read back the shadow value last written. The remaining configuration words read back the working copy in use.
- R7: The interrupt register sits at offset 0x3C. Its bits 3:0 are sticky status for frame end, display end, per-frame and line flag, in that order. A high pulse on `ev_pulse[k]` sets bit k at the next edge, and the bit stays set.
- R8: Bits 7:4 of 0x3C are read/write mask bits for the same four events, in the same order. `irq` is high exactly when some status bit has its mask bit set.
- R9: Writing 1 to bit 8+k of 0x3C clears status bit k. These clear bits always read as 0. If an event sets a bit in the same cycle as its clear, the bit stays set.
- R10: Bus writes to status bits 3:0 have no effect on status.
- R11: Unmapped or misaligned addresses read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| frame_edge | input | 1 | Frame boundary strobe from the timing logic |
| tg_idle | input | 1 | Timing logic is idle |
| ev_pulse | input | 4 | Event pulses: frame end, display end, per-frame, line flag |
| cfg_work | output | NUM_CFG*32 | Working configuration words, word i at bits 32*i+31:32*i |
| load_pulse | output | 1 | High in the cycle a global load is applied |
| irq | output | 1 | Interrupt line |

## Verification
The load path is tried three ways. In the first, the load waits for a frame boundary, which shows that shadow and working copies really are separate. In the second, the timing logic is idle, which shows the immediate path. In the third, config-done is written with bit 0 clear, which shows that only bit 0 arms the load. Readback is tried on a word that reads its shadow and on a word that reads its working copy, which tells the two readback groups apart. The interrupt register is driven with masked and unmasked events, with a clear on its own, and with a clear that coincides with a new event. These cases separate the set-wins priority, the masking and the clear-bit readback. Writes to the status field, and to unmapped and misaligned addresses, show that these writes leave all state unchanged.

// File: rtl/cfgrf_pkg.sv
package cfgrf_pkg;
  localparam int WORD_W = 32;
  localparam int EV_N   = 4;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CFG,
    SEL_IRQ,
    SEL_DONE
  } sel_e;

  // Interrupt register image: status [3:0], mask [7:4], clear [11:8] reads 0.
  function automatic logic [WORD_W-1:0] irq_image(input logic [EV_N-1:0] st,
                                                  input logic [EV_N-1:0] mk);
    logic [WORD_W-1:0] w;
    w = '0;
    w[EV_N-1:0]      = st;
    w[2*EV_N-1:EV_N] = mk;
    return w;
  endfunction
endpackage

// File: rtl/cfgrf_addr_dec.sv
module cfgrf_addr_dec
  import cfgrf_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_CFG  = 8,
  parameter int IRQ_OFS  = 'h3C,
  parameter int DONE_OFS = 'h50,
  localparam int IDX_W   = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel,
  output logic [IDX_W-1:0]  idx
);
  localparam int WA_W = ADDR_W - 2;

  logic [WA_W-1:0] word;
  logic            aligned;

  assign word    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign idx     = word[IDX_W-1:0];

  always_comb begin
    sel = SEL_NONE;
    if (aligned) begin
      if (int'(word) < NUM_CFG)             sel = SEL_CFG;
      else if (int'(word) == IRQ_OFS / 4)   sel = SEL_IRQ;
      else if (int'(word) == DONE_OFS / 4)  sel = SEL_DONE;
    end
  end
endmodule

// File: rtl/cfgrf_bank.sv
module cfgrf_bank
  import cfgrf_pkg::*;
#(
  parameter int NUM_CFG = 8,
  localparam int IDX_W  = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr,
  input  logic [IDX_W-1:0]          idx,
  input  logic [WORD_W-1:0]         wdata,
  input  logic                      load,
  output logic [NUM_CFG*WORD_W-1:0] shadow,
  output logic [NUM_CFG*WORD_W-1:0] work
);
  for (genvar i = 0; i < NUM_CFG; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow[i*WORD_W +: WORD_W] <= '0;
      end else if (wr && (int'(idx) == i)) begin
        shadow[i*WORD_W +: WORD_W] <= wdata;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        work[i*WORD_W +: WORD_W] <= '0;
      end else if (load) begin
        work[i*WORD_W +: WORD_W] <= shadow[i*WORD_W +: WORD_W];
      end
    end
  end
endmodule

// File: rtl/cfgrf_load_ctl.sv
module cfgrf_load_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic frame_edge,
  input  logic tg_idle,
  output logic pending,
  output logic load
);
  assign load = pending & (frame_edge | tg_idle);

  always_ff @(posedge clk) begin
    if (!rst_n)        pending <= 1'b0;
    else if (arm)      pending <= 1'b1;
    else if (load)     pending <= 1'b0;
  end
endmodule

// File: rtl/cfgrf_irq.sv
module cfgrf_irq
  import cfgrf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [3*EV_N-1:0] wdata,
  input  logic [EV_N-1:0]   ev,
  output logic [EV_N-1:0]   status,
  output logic [EV_N-1:0]   mask,
  output logic [EV_N-1:0]   clr_req,
  output logic              irq
);
  assign clr_req = wr ? wdata[3*EV_N-1:2*EV_N] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= '0;
    end else begin
      status <= (status & ~clr_req) | ev;
      if (wr) mask <= wdata[2*EV_N-1:EV_N];
    end
  end

  assign irq = |(status & mask);
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfgrf_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_CFG   = 8,
  parameter int SHADOW_RB = 3,
  parameter int IRQ_OFS   = 'h3C,
  parameter int DONE_OFS  = 'h50
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  input  logic                      frame_edge,
  input  logic                      tg_idle,
  input  logic [3:0]                ev_pulse,
  output logic [NUM_CFG*32-1:0]     cfg_work,
  output logic                      load_pulse,
  output logic                      irq
);
  localparam int IDX_W = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1;

  sel_e                      sel;
  logic [IDX_W-1:0]          cfg_idx;
  logic [NUM_CFG*WORD_W-1:0] cfg_shadow;
  logic                      done_set;
  logic                      pending;
  logic [EV_N-1:0]           ev_status;
  logic [EV_N-1:0]           ev_mask;
  logic [EV_N-1:0]           clr_req;

  cfgrf_addr_dec #(
    .ADDR_W(ADDR_W), .NUM_CFG(NUM_CFG), .IRQ_OFS(IRQ_OFS), .DONE_OFS(DONE_OFS)
  ) u_dec (
    .addr(bus_addr), .sel(sel), .idx(cfg_idx)
  );

  cfgrf_bank #(.NUM_CFG(NUM_CFG)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr(bus_wr && (sel == SEL_CFG)), .idx(cfg_idx), .wdata(bus_wdata),
    .load(load_pulse), .shadow(cfg_shadow), .work(cfg_work)
  );

  assign done_set = bus_wr && (sel == SEL_DONE) && bus_wdata[0];

  cfgrf_load_ctl u_load (
    .clk(clk), .rst_n(rst_n), .arm(done_set),
    .frame_edge(frame_edge), .tg_idle(tg_idle),
    .pending(pending), .load(load_pulse)
  );

  cfgrf_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .wr(bus_wr && (sel == SEL_IRQ)), .wdata(bus_wdata[3*EV_N-1:0]),
    .ev(ev_pulse), .status(ev_status), .mask(ev_mask),
    .clr_req(clr_req), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      SEL_CFG:  bus_rdata = (int'(cfg_idx) < SHADOW_RB)
                            ? cfg_shadow[cfg_idx*WORD_W +: WORD_W]
                            : cfg_work[cfg_idx*WORD_W +: WORD_W];
      SEL_IRQ:  bus_rdata = irq_image(ev_status, ev_mask);
      SEL_DONE: bus_rdata = {31'b0, pending};
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cfg_regfile_chk.sv
module cfg_regfile_chk #(
  parameter int NUM_CFG = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  done_set,
  input logic                  pending,
  input logic                  load_pulse,
  input logic [NUM_CFG*32-1:0] cfg_work,
  input logic [3:0]            ev_status,
  input logic [3:0]            ev_mask,
  input logic [3:0]            clr_req,
  input logic [3:0]            ev_pulse,
  input logic                  irq
);
  // R2: the working copy moves only on a load
  a_r2_work_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !load_pulse |=> $stable(cfg_work));

  // R4: a load with no new arm leaves the flag clear
  a_r4_load_clears_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (load_pulse && !done_set) |=> !pending);

  // R3: an arm always leaves the flag set
  a_r3_arm_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    done_set |=> pending);

  // R7, R9: an event sets its bit even against a clear
  a_r7_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pulse != 4'b0) |=> ((ev_status & $past(ev_pulse)) == $past(ev_pulse)));

  // R9: a status bit falls only after a clear request
  a_r9_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~ev_status & $past(ev_status) & ~$past(clr_req)) == 4'b0));

  // R8: no interrupt with everything masked
  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_mask == 4'b0) |-> !irq);
endmodule

bind cfg_regfile cfg_regfile_chk #(.NUM_CFG(NUM_CFG)) u_chk (
  .clk(clk), .rst_n(rst_n), .done_set(done_set), .pending(pending),
  .load_pulse(load_pulse), .cfg_work(cfg_work), .ev_status(ev_status),
  .ev_mask(ev_mask), .clr_req(clr_req), .ev_pulse(ev_pulse), .irq(irq)
);

// File: tb/tb_cfg_regfile.sv
module tb_cfg_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W  = 8;
  localparam int NUM_CFG = 8;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  bus_wr = 1'b0;
  logic [ADDR_W-1:0]     bus_addr = '0;
  logic [31:0]           bus_wdata = '0;
  logic [31:0]           bus_rdata;
  logic                  frame_edge = 1'b0;
  logic                  tg_idle = 1'b0;
  logic [3:0]            ev_pulse = '0;
  logic [NUM_CFG*32-1:0] cfg_work;
  logic                  load_pulse;
  logic                  irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_regfile #(.ADDR_W(ADDR_W), .NUM_CFG(NUM_CFG)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_edge(frame_edge),
    .tg_idle(tg_idle), .ev_pulse(ev_pulse), .cfg_work(cfg_work),
    .load_pulse(load_pulse), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] work_word(input int i);
    return cfg_work[i*32 +: 32];
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 work zero", (cfg_work == '0) ? 32'd1 : 32'd0, 32'd1);
    chk("R1 irq low", {31'b0, irq}, 32'd0);
    rd(8'h50, v); chk("R1 pending zero", v, 32'd0);
    rd(8'h3C, v); chk("R1 irq reg zero", v, 32'd0);
    rd(8'h04, v); chk("R1 shadow zero", v, 32'd0);
  endtask

  task automatic t_frame_load();
    logic [31:0] v;
    wr(8'h0C, 32'hCAFE_0123);
    wr(8'h50, 32'h0000_0001);
    chk("R2 work held", work_word(3), 32'd0);
    rd(8'h50, v); chk("R3 pending set", v, 32'd1);
    rd(8'h0C, v); chk("R6 working readback before load", v, 32'd0);
    @(negedge clk); frame_edge = 1'b1;
    #1 chk("R4 load_pulse", {31'b0, load_pulse}, 32'd1);
    @(negedge clk); frame_edge = 1'b0;
    chk("R4 work loaded", work_word(3), 32'hCAFE_0123);
    rd(8'h50, v); chk("R4 pending cleared", v, 32'd0);
    rd(8'h0C, v); chk("R6 working readback after load", v, 32'hCAFE_0123);
  endtask

  task automatic t_no_arm();
    logic [31:0] v;
    wr(8'h10, 32'h1111_2222);
    wr(8'h50, 32'hFFFF_FFFE);
    rd(8'h50, v); chk("R3 bit0 clear ignored", v, 32'd0);
    @(negedge clk); frame_edge = 1'b1;
    @(negedge clk); frame_edge = 1'b0;
    chk("R3 no load without arm", work_word(4), 32'd0);
  endtask

  task automatic t_idle_load();
    logic [31:0] v;
    wr(8'h04, 32'h0BAD_F00D);
    rd(8'h04, v); chk("R6 shadow readback", v, 32'h0BAD_F00D);
    chk("R2 word1 held", work_word(1), 32'd0);
    tg_idle = 1'b1;
    wr(8'h50, 32'h1);
    @(negedge clk);
    chk("R5 idle load", work_word(1), 32'h0BAD_F00D);
    chk("R5 earlier word kept", work_word(4), 32'h1111_2222);
    rd(8'h50, v); chk("R5 pending cleared", v, 32'd0);
    tg_idle = 1'b0;
  endtask

  task automatic t_irq_mask();
    logic [31:0] v;
    wr(8'h3C, 32'h0000_00F0);
    @(negedge clk); ev_pulse = 4'b0010;
    @(negedge clk); ev_pulse = 4'b0000;
    rd(8'h3C, v); chk("R7 display-end sticky", v, 32'h0000_00F2);
    chk("R8 irq unmasked", {31'b0, irq}, 32'd1);
    wr(8'h3C, 32'h0000_0200);
    rd(8'h3C, v); chk("R9 cleared and mask written 0", v, 32'h0000_0000);
    @(negedge clk); ev_pulse = 4'b1000;
    @(negedge clk); ev_pulse = 4'b0000;
    rd(8'h3C, v); chk("R7 line flag status", v, 32'h0000_0008);
    chk("R8 irq masked", {31'b0, irq}, 32'd0);
    wr(8'h3C, 32'h0000_0080);
    #1 chk("R8 irq after unmask", {31'b0, irq}, 32'd1);
    wr(8'h3C, 32'h0000_0880);
    rd(8'h3C, v); chk("R9 clear reads zero", v, 32'h0000_0080);
    chk("R8 irq drops", {31'b0, irq}, 32'd0);
  endtask

  task automatic t_clear_race();
    logic [31:0] v;
    @(negedge clk); ev_pulse = 4'b0001;
    @(negedge clk); ev_pulse = 4'b0000;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h3C; bus_wdata = 32'h0000_0100; ev_pulse = 4'b0001;
    @(negedge clk);
    bus_wr = 1'b0; ev_pulse = 4'b0000;
    rd(8'h3C, v); chk("R9 set wins over clear", v, 32'h0000_0001);
    wr(8'h3C, 32'h0000_010F);
    rd(8'h3C, v); chk("R10 status not writable", v, 32'h0000_0000);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(8'h44, 32'hFFFF_FFFF);
    rd(8'h44, v); chk("R11 unmapped reads zero", v, 32'd0);
    wr(8'h05, 32'h0000_0001);
    rd(8'h05, v); chk("R11 misaligned reads zero", v, 32'd0);
    rd(8'h04, v); chk("R11 word1 untouched", v, 32'h0BAD_F00D);
    wr(8'h51, 32'h0000_0001);
    rd(8'h50, v); chk("R11 misaligned done ignored", v, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_frame_load();
    t_no_arm();
    t_idle_load();
    t_irq_mask();
    t_clear_race();
    t_unmapped();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule